// File: doc/BRIEF.md
# Flash Write Permission Guard

This block sits in front of a flash array and rules on every CPU write request to the flash address map. Each request falls into one of four areas. The boot area runs from address zero up to a programmable limit and is never writable. The code area lies above that limit and has one enable bit for each 8 KB section. The data area is a small window with one enable bit for each 512-byte section. Any address outside these three areas is refused. A write to the code or data area is allowed only when its section bit is set and a global lock is off.

The global write lock and a debugger read lock come from two 3-bit fields of a protection word. Each lock is on when most of its three bits are zero. The debugger read lock affects only reads by an external debugger or programmer. CPU reads pass by this block untouched.

Software controls the section enable bits through three 16-bit registers with a small select-based write/read port. The verdict for a request appears one clock after the request as a permit flag or a violation pulse.

Top module: `flash_wr_guard`

## Requirements
- R1: The boot limit is L = min(boot_end, 0x77FF). Any CPU write with address below L is refused (violation), whatever the enable bits and the write-lock field hold.
- R2: After synchronous reset, all three enable registers read back as 0x0000 and every CPU write is refused.
- R3: The code area is L <= address <= 0x3FFFF. Its section index is address[17:13]. Sections 0-15 use bits 0-15 of register select 0, and sections 16-31 use bits 0-15 of register select 1.
- R4: The data area is 0xD0000 <= address <= 0xD1FFF. Its section index is address[12:9], which selects bits 0-15 of register select 2.
- R5: When two or three bits of wr_prot are 0, every CPU write is refused.
- R6: A CPU write to an address outside the boot, code and data areas is refused.
- R7: A cpu_wr in cycle N sets exactly one of wr_permit and wr_violation in cycle N+1, each for one cycle. When cpu_wr is low, both are low in the next cycle.
- R8: dbg_rd_permit is 1 one cycle after rd_prot has two or three bits set, and 0 otherwise.
- R9: cfg_wr_en with cfg_wr_sel 0, 1 or 2 loads all 16 bits of that register. Select 3 changes nothing. cfg_rd_data shows the register picked by cfg_rd_sel one cycle later, and reads 0 for select 3.
- R10: A CPU write is judged against the enable values held before any register write made in the same cycle.
- R11: A boot_end value above 0x77FF acts as 0x77FF. Address 0x77FF is then in the code area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Enable register write strobe |
| cfg_wr_sel | input | 2 | Register select for writes (0,1 program, 2 data) |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_sel | input | 2 | Register select for readback |
| cfg_rd_data | output | 16 | Registered readback data |
| boot_end | input | 20 | Programmable boot-area limit |
| wr_prot | input | 3 | Global write-lock field |
| rd_prot | input | 3 | Global debugger read-lock field |
| cpu_addr | input | 20 | CPU write address |
| cpu_wr | input | 1 | CPU write strobe |
| wr_permit | output | 1 | Write allowed (one cycle after request) |
| wr_violation | output | 1 | Write refused (one-cycle pulse) |
| dbg_rd_permit | output | 1 | External debugger reads allowed |

## Verification
An enable-register update and a CPU write that the same bit governs can land in the same cycle. The bench provokes this on purpose: it clears a register, then in one cycle sets the register while writing to one of its sections. It expects a violation in that cycle and a permit on an identical write in the next cycle. Random stimulus also mixes register writes with CPU writes. A bench model whose state updates only after each cycle's verdict judges every one of these cases.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [1:0] {
    AREA_BOOT = 2'd0,
    AREA_CODE = 2'd1,
    AREA_DATA = 2'd2,
    AREA_NONE = 2'd3
  } area_e;

  // True when at least two of the three bits are zero.
  function automatic logic majority_zero(input logic [2:0] v);
    return (~v[0] & ~v[1]) | (~v[0] & ~v[2]) | (~v[1] & ~v[2]);
  endfunction

endpackage

// File: rtl/flash_area_decode.sv
module flash_area_decode
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BOOT_MAX   = 'h77FF,
  parameter int CODE_LAST  = 'h3FFFF,
  parameter int DATA_BASE  = 'hD0000,
  parameter int DATA_LAST  = 'hD1FFF,
  parameter int PSEC_SHIFT = 13,
  parameter int DSEC_SHIFT = 9,
  parameter int PSEC_W     = 5,
  parameter int DSEC_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] boot_end,
  output area_e             area,
  output logic [PSEC_W-1:0] psec,
  output logic [DSEC_W-1:0] dsec
);

  localparam logic [ADDR_W-1:0] BOOT_CAP  = ADDR_W'(BOOT_MAX);
  localparam logic [ADDR_W-1:0] CODE_TOP  = ADDR_W'(CODE_LAST);
  localparam logic [ADDR_W-1:0] DATA_LO   = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] DATA_HI   = ADDR_W'(DATA_LAST);

  logic [ADDR_W-1:0] boot_lim;

  always_comb begin
    boot_lim = (boot_end > BOOT_CAP) ? BOOT_CAP : boot_end;
  end

  always_comb begin
    if (addr < boot_lim)
      area = AREA_BOOT;
    else if (addr <= CODE_TOP)
      area = AREA_CODE;
    else if ((addr >= DATA_LO) && (addr <= DATA_HI))
      area = AREA_DATA;
    else
      area = AREA_NONE;
  end

  assign psec = addr[PSEC_SHIFT +: PSEC_W];
  assign dsec = addr[DSEC_SHIFT +: DSEC_W];

endmodule

// File: rtl/flash_wen_bank.sv
module flash_wen_bank #(
  parameter int REG_W  = 16,
  parameter int SEL_W  = 2,
  parameter int PSEC_W = 5,
  parameter int DSEC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic [PSEC_W-1:0] psec,
  input  logic [DSEC_W-1:0] dsec,
  output logic              prog_bit,
  output logic              data_bit
);

  localparam int NUM_BANKS = 3;
  localparam int PROG_BITS = 2 * REG_W;

  logic [REG_W-1:0]     bank_q [NUM_BANKS];
  logic [REG_W-1:0]     rd_q;
  logic [PROG_BITS-1:0] prog_vec;
  logic [NUM_BANKS*REG_W-1:0] all_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) bank_q[b] <= '0;
    end else if (cfg_wr_en) begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (cfg_wr_sel == SEL_W'(b)) bank_q[b] <= cfg_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        if (cfg_rd_sel == SEL_W'(b)) rd_q <= bank_q[b];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_flat
      assign all_bits[g*REG_W +: REG_W] = bank_q[g];
    end
  endgenerate

  assign cfg_rd_data = rd_q;
  assign prog_vec    = all_bits[PROG_BITS-1:0];
  assign prog_bit    = prog_vec[psec];
  assign data_bit    = bank_q[2][dsec];

  // R2: registers come out of reset cleared
  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (all_bits == '0));

  // R9: select 3 leaves every register unchanged
  p_sel3_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_sel == SEL_W'(3)) |=> $stable(all_bits));

endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int REG_W      = 16,
  parameter int SEL_W      = 2,
  parameter int BOOT_MAX   = 'h77FF,
  parameter int CODE_LAST  = 'h3FFFF,
  parameter int DATA_BASE  = 'hD0000,
  parameter int DATA_LAST  = 'hD1FFF,
  parameter int PSEC_SHIFT = 13,
  parameter int DSEC_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic [ADDR_W-1:0] boot_end,
  input  logic [2:0]        wr_prot,
  input  logic [2:0]        rd_prot,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic              wr_permit,
  output logic              wr_violation,
  output logic              dbg_rd_permit
);

  localparam int PSEC_W = $clog2(2 * REG_W);
  localparam int DSEC_W = $clog2(REG_W);

  area_e             area;
  logic [PSEC_W-1:0] psec;
  logic [DSEC_W-1:0] dsec;
  logic              prog_bit;
  logic              data_bit;
  logic              sec_ok;
  logic              allow;
  logic              permit_q, viol_q, dbg_q;

  flash_area_decode #(
    .ADDR_W(ADDR_W), .BOOT_MAX(BOOT_MAX), .CODE_LAST(CODE_LAST),
    .DATA_BASE(DATA_BASE), .DATA_LAST(DATA_LAST),
    .PSEC_SHIFT(PSEC_SHIFT), .DSEC_SHIFT(DSEC_SHIFT),
    .PSEC_W(PSEC_W), .DSEC_W(DSEC_W)
  ) u_decode (
    .addr(cpu_addr), .boot_end(boot_end),
    .area(area), .psec(psec), .dsec(dsec)
  );

  flash_wen_bank #(
    .REG_W(REG_W), .SEL_W(SEL_W), .PSEC_W(PSEC_W), .DSEC_W(DSEC_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .psec(psec), .dsec(dsec),
    .prog_bit(prog_bit), .data_bit(data_bit)
  );

  always_comb begin
    unique case (area)
      AREA_CODE: sec_ok = prog_bit;
      AREA_DATA: sec_ok = data_bit;
      default:   sec_ok = 1'b0;
    endcase
    allow = sec_ok & ~majority_zero(wr_prot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      permit_q <= 1'b0;
      viol_q   <= 1'b0;
      dbg_q    <= 1'b0;
    end else begin
      permit_q <= cpu_wr & allow;
      viol_q   <= cpu_wr & ~allow;
      dbg_q    <= ~majority_zero(rd_prot);
    end
  end

  assign wr_permit     = permit_q;
  assign wr_violation  = viol_q;
  assign dbg_rd_permit = dbg_q;

  // R1: boot area writes are always refused
  p_boot_refused_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && area == AREA_BOOT) |=> (wr_violation && !wr_permit));

  // R5: global lock refuses everything
  p_global_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && $countones(wr_prot) <= 1) |=> !wr_permit);

  // R6: unmapped addresses are refused
  p_unmapped_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && area == AREA_NONE) |=> wr_violation);

  // R7: one verdict per request, none without one
  p_one_verdict_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_wr |=> (wr_permit != wr_violation));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> (!wr_permit && !wr_violation));

  // R8: debugger lock
  p_dbg_lock_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones(rd_prot) <= 1) |=> !dbg_rd_permit);

endmodule

// File: tb/flash_wr_guard_bench.sv
module flash_wr_guard_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [1:0]  cfg_wr_sel;
  logic [15:0] cfg_wr_data;
  logic [1:0]  cfg_rd_sel;
  logic [15:0] cfg_rd_data;
  logic [19:0] boot_end;
  logic [2:0]  wr_prot, rd_prot;
  logic [19:0] cpu_addr;
  logic        cpu_wr;
  logic        wr_permit, wr_violation, dbg_rd_permit;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_en [3];

  always #4 clk = ~clk;

  flash_wr_guard u_flash_wr_guard (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .boot_end(boot_end), .wr_prot(wr_prot), .rd_prot(rd_prot),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .wr_permit(wr_permit), .wr_violation(wr_violation),
    .dbg_rd_permit(dbg_rd_permit)
  );

  function automatic logic exp_allow(input logic [19:0] a, input logic [19:0] be,
                                     input logic [2:0] wp);
    logic [19:0] lim;
    logic        bit_ok;
    lim = (be > 20'h77FF) ? 20'h77FF : be;
    if (a < lim) bit_ok = 1'b0;
    else if (a <= 20'h3FFFF) bit_ok = {m_en[1], m_en[0]}[a[17:13]];
    else if (a >= 20'hD0000 && a <= 20'hD1FFF) bit_ok = m_en[2][a[12:9]];
    else bit_ok = 1'b0;
    return bit_ok && ($countones(wp) >= 2);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] ws, input logic [15:0] wd,
                     input logic cw, input logic [19:0] a, input logic [19:0] be,
                     input logic [2:0] wp, input logic [2:0] rp,
                     input logic [1:0] rs, input string req);
    logic        al;
    logic [15:0] erd;
    al  = exp_allow(a, be, wp);
    erd = (rs == 2'd3) ? 16'h0 : m_en[rs];
    cfg_wr_en = we; cfg_wr_sel = ws; cfg_wr_data = wd;
    cpu_wr = cw; cpu_addr = a; boot_end = be; wr_prot = wp; rd_prot = rp;
    cfg_rd_sel = rs;
    @(posedge clk);
    @(negedge clk);
    chk({req, " permit"},    16'(wr_permit),     16'(cw & al));
    chk({req, " violation"}, 16'(wr_violation),  16'(cw & ~al));
    chk({req, " dbg R8"},    16'(dbg_rd_permit), 16'($countones(rp) >= 2));
    chk({req, " readback R9"}, cfg_rd_data, erd);
    if (we && ws != 2'd3) m_en[ws] = wd;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 3; i++) m_en[i] = 16'h0;
    rst = 1'b1; cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0; cfg_rd_sel = 0;
    boot_end = 0; wr_prot = 3'b111; rd_prot = 3'b111; cpu_addr = 0; cpu_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2: reset state readback and refusal
    for (int s = 0; s < 3; s++)
      cyc(0, 0, 0, 1, 20'h10000, 20'h1000, 3'b111, 3'b111, 2'(s), "R2 reset");
    cyc(0, 0, 0, 1, 20'hD0200, 20'h1000, 3'b111, 3'b011, 2'd0, "R2 data reset");

    // R9: load all registers, select 3 ignored
    cyc(1, 0, 16'hFFFF, 0, 0, 20'h1000, 3'b111, 3'b111, 2'd0, "R9 load0");
    cyc(1, 1, 16'hFFFF, 0, 0, 20'h1000, 3'b111, 3'b111, 2'd0, "R9 load1");
    cyc(1, 2, 16'hFFFF, 0, 0, 20'h1000, 3'b111, 3'b111, 2'd1, "R9 load2");
    cyc(1, 3, 16'h1234, 0, 0, 20'h1000, 3'b111, 3'b111, 2'd2, "R9 sel3");
    cyc(0, 0, 0, 0, 0, 20'h1000, 3'b111, 3'b111, 2'd3, "R9 sel3 read");
    for (int s = 0; s < 3; s++)
      cyc(0, 0, 0, 0, 0, 20'h1000, 3'b111, 3'b111, 2'(s), "R9 after sel3");

    // R1: boot writes refused with all enables on
    cyc(0, 0, 0, 1, 20'h0000, 20'h4000, 3'b111, 3'b110, 2'd0, "R1 boot base");
    cyc(0, 0, 0, 1, 20'h3FFF, 20'h4000, 3'b111, 3'b101, 2'd0, "R1 boot top");
    cyc(0, 0, 0, 1, 20'h4000, 20'h4000, 3'b111, 3'b100, 2'd0, "R3 code first");
    // R11: clamp
    cyc(0, 0, 0, 1, 20'h77FE, 20'hFFFFF, 3'b111, 3'b111, 2'd0, "R11 below clamp");
    cyc(0, 0, 0, 1, 20'h77FF, 20'hFFFFF, 3'b111, 3'b111, 2'd0, "R11 at clamp");
    // R3/R4 edges, R6 outside
    cyc(0, 0, 0, 1, 20'h3FFFF, 20'h0, 3'b111, 3'b111, 2'd0, "R3 code last");
    cyc(0, 0, 0, 1, 20'h40000, 20'h0, 3'b111, 3'b111, 2'd0, "R6 after code");
    cyc(0, 0, 0, 1, 20'hCFFFF, 20'h0, 3'b111, 3'b111, 2'd0, "R6 below data");
    cyc(0, 0, 0, 1, 20'hD0000, 20'h0, 3'b111, 3'b111, 2'd0, "R4 data first");
    cyc(0, 0, 0, 1, 20'hD1FFF, 20'h0, 3'b111, 3'b111, 2'd0, "R4 data last");
    cyc(0, 0, 0, 1, 20'hD2000, 20'h0, 3'b111, 3'b111, 2'd0, "R6 after data");
    // R5: global lock
    cyc(0, 0, 0, 1, 20'h20000, 20'h0, 3'b100, 3'b111, 2'd0, "R5 lock one set");
    cyc(0, 0, 0, 1, 20'h20000, 20'h0, 3'b000, 3'b111, 2'd0, "R5 lock none set");
    cyc(0, 0, 0, 1, 20'h20000, 20'h0, 3'b011, 3'b111, 2'd0, "R5 unlocked");
    // R3: single section bits in each program register
    cyc(1, 0, 16'h0004, 0, 0, 20'h0, 3'b111, 3'b111, 2'd0, "R3 set sec2");
    cyc(0, 0, 0, 1, 20'h04000, 20'h0, 3'b111, 3'b111, 2'd0, "R3 sec2 on");
    cyc(0, 0, 0, 1, 20'h06000, 20'h0, 3'b111, 3'b111, 2'd0, "R3 sec3 off");
    cyc(1, 1, 16'h8000, 0, 0, 20'h0, 3'b111, 3'b111, 2'd1, "R3 set sec31");
    cyc(0, 0, 0, 1, 20'h3E000, 20'h0, 3'b111, 3'b111, 2'd1, "R3 sec31 on");
    cyc(0, 0, 0, 1, 20'h3C000, 20'h0, 3'b111, 3'b111, 2'd1, "R3 sec30 off");
    cyc(1, 2, 16'h0002, 0, 0, 20'h0, 3'b111, 3'b111, 2'd2, "R4 set dsec1");
    cyc(0, 0, 0, 1, 20'hD0200, 20'h0, 3'b111, 3'b111, 2'd2, "R4 dsec1 on");
    cyc(0, 0, 0, 1, 20'hD0000, 20'h0, 3'b111, 3'b111, 2'd2, "R4 dsec0 off");
    // R10: same-cycle update and request
    cyc(1, 0, 16'h0000, 0, 0, 20'h0, 3'b111, 3'b111, 2'd0, "R10 clear");
    cyc(1, 0, 16'h0001, 1, 20'h00100, 20'h0, 3'b111, 3'b111, 2'd0, "R10 collide");
    cyc(0, 0, 0, 1, 20'h00100, 20'h0, 3'b111, 3'b111, 2'd0, "R10 after");
    cyc(1, 0, 16'h0000, 1, 20'h00100, 20'h0, 3'b111, 3'b111, 2'd0, "R10 collide clear");
    // R7: idle cycle
    cyc(0, 0, 0, 0, 20'h00100, 20'h0, 3'b111, 3'b111, 2'd0, "R7 idle");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] a;
      logic [19:0] be;
      int k;
      k = $urandom_range(0, 3);
      case (k)
        0: a = 20'($urandom_range(0, 'hFFFF));
        1: a = 20'($urandom_range(0, 'h3FFFF));
        2: a = 20'($urandom_range('hCFF00, 'hD20FF));
        default: a = 20'($urandom);
      endcase
      be = ($urandom_range(0, 3) == 0) ? 20'($urandom) : 20'($urandom_range(0, 'h8000));
      cyc(($urandom_range(0, 3) == 0), 2'($urandom), 16'($urandom),
          ($urandom_range(0, 3) != 0), a, be,
          ($urandom_range(0, 4) == 0) ? 3'($urandom) : 3'b111,
          3'($urandom), 2'($urandom), "R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule